// File: doc/BRIEF.md
# Keyed Write-Access Gate for a Timekeeping Register File

This block sits in front of the registers of a battery-backed timekeeping unit and decides which bus writes may reach them. Two keyed sequences guard the file. A 32-bit start-up word, written once, moves the block from its power-up reset state into a permanent active state. A 16-bit password opens a write window that stays open for a fixed number of slow timekeeping clock enables and then closes by itself. A wrong password shuts the window immediately.

A rate limiter watches every bus write. When too many writes fall inside a sliding window of bus-clock cycles, it raises a busy flag. While busy is high the window reads as closed and protected writes are held back. Downstream registers take their write strobe from `prot_we_o` and never from the raw bus strobe.

Top module: `rtc_access_gate`

## Requirements
- R1: After reset, `active_o`, `win_open_o`, `busy_o` and `prot_we_o` are 0, and reads of the start-up register (offset 0x0) and the access register (offset 0x4) return 0.
- R2: A write of exactly 0xA5EB1357 to offset 0x0 sets `active_o` from the next cycle. Any other value leaves the block in the reset state. Once set, `active_o` stays 1 until reset, whatever is written later.
- R3: A read of offset 0x0 returns the active flag in bit 0 and zeros in bits 31:1.
- R4: A write to offset 0x4 whose bits 15:0 equal 0xA965 opens the window from the next cycle. A read of offset 0x4 shows the window flag in bit 16, and bits 15:0 always read as 0.
- R5: The window closes on the WIN_SLOW-th `slow_en_i` pulse after it was opened. A new key write while the window is open restarts this count.
- R6: A write to offset 0x4 whose bits 15:0 differ from 0xA965 closes the window from the next cycle.
- R7: `busy_o`, which also reads as bit 24 of offset 0x4, is 1 while more than RATE_MAX bus writes have occurred within the last RATE_WIN cycles. It returns to 0 once that count falls to RATE_MAX or below.
- R8: While `busy_o` is 1, `win_open_o` and bit 16 of offset 0x4 read as 0. They return to 1 when busy clears, provided the window has not expired.
- R9: `prot_we_o` follows `wr_i` for any address other than 0x0 and 0x4, but only when the block is active, the window is open and busy is 0. In every other case it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_en_i | input | 1 | One-cycle pulse per slow timekeeping clock |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data for offsets 0x0 and 0x4, zero otherwise |
| active_o | output | 1 | Block has left its reset state |
| win_open_o | output | 1 | Write window open and not masked by busy |
| busy_o | output | 1 | Write-rate limit exceeded |
| prot_we_o | output | 1 | Gated write enable for protected registers |

## Verification
The bench builds the gate with WIN_SLOW=8, RATE_WIN=32 and RATE_MAX=6 instead of the default 1024 slow clocks and 1120 bus cycles. The short window lets the bench reach both the expiry edge and the key-restart case in a few dozen cycles. The short rate window lets it run a back-to-back write burst that crosses the busy threshold exactly at the seventh write, and then watch busy drain. Normal writes are spaced far enough apart that the rate limiter never trips outside the burst scenario.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam logic [31:0] INIT_KEY = 32'hA5EB_1357;
  localparam logic [15:0] WIN_KEY  = 16'hA965;
  localparam logic [31:0] INIT_OFS = 32'h0000_0000;
  localparam logic [31:0] ACC_OFS  = 32'h0000_0004;
  localparam int          ACT_BIT  = 0;
  localparam int          WEN_BIT  = 16;
  localparam int          BUSY_BIT = 24;

  typedef struct packed {
    logic init_wr;
    logic acc_wr;
    logic prot_wr;
  } bus_dec_t;
endpackage

// File: rtl/gate_activation.sv
module gate_activation (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_wr_i,
  input  logic key_ok_i,
  output logic active_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    active_q <= 1'b0;
    else if (init_wr_i && key_ok_i) active_q <= 1'b1;
  end

  assign active_o = active_q;

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q);
  a_r2_rise_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(init_wr_i && key_ok_i));
endmodule

// File: rtl/gate_window.sv
module gate_window #(
  parameter int WIN_SLOW = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_wr_i,
  input  logic key_ok_i,
  input  logic slow_en_i,
  output logic open_o
);
  localparam int CW = $clog2(WIN_SLOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_SLOW - 1);

  logic          open_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc_wr_i) begin
      open_q <= key_ok_i;   // key restarts, anything else closes
      cnt_q  <= '0;
    end else if (open_q && slow_en_i) begin
      if (cnt_q == LAST) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign open_o = open_q;

  a_r4_key_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && key_ok_i) |=> open_q);
  a_r6_bad_key_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr_i && !key_ok_i) |=> !open_q);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r5_hold_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !acc_wr_i && !slow_en_i) |=> (open_q && $stable(cnt_q)));
endmodule

// File: rtl/gate_rate_limiter.sv
module gate_rate_limiter #(
  parameter int RATE_WIN = 1120,
  parameter int RATE_MAX = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic busy_o
);
  localparam int NW = $clog2(RATE_WIN + 1);

  logic [RATE_WIN-1:0] hist_q;
  logic [NW-1:0]       cnt_q;
  logic [NW-1:0]       cnt_d;

  // one history bit per cycle; count tracks ones inside the window
  always_comb begin
    cnt_d = cnt_q;
    if (wr_i && !hist_q[RATE_WIN-1])      cnt_d = cnt_q + 1'b1;
    else if (!wr_i && hist_q[RATE_WIN-1]) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= {hist_q[RATE_WIN-2:0], wr_i};
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = (cnt_q > NW'(RATE_MAX));

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NW'(RATE_WIN));
  a_r7_rise_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_i));
  a_r7_idle_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !$rose(busy_o));
endmodule

// File: rtl/rtc_access_gate.sv
module rtc_access_gate
  import gate_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int WIN_SLOW = 1024,
  parameter int RATE_WIN = 1120,
  parameter int RATE_MAX = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [31:0]       rdata_o,
  output logic              active_o,
  output logic              win_open_o,
  output logic              busy_o,
  output logic              prot_we_o
);
  bus_dec_t dec;
  logic     hit_init, hit_acc;
  logic     active, win_raw, busy;

  assign hit_init = (addr_i == INIT_OFS[ADDR_W-1:0]);
  assign hit_acc  = (addr_i == ACC_OFS[ADDR_W-1:0]);

  assign dec.init_wr = wr_i && hit_init;
  assign dec.acc_wr  = wr_i && hit_acc;
  assign dec.prot_wr = wr_i && !hit_init && !hit_acc;

  gate_activation i_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_wr_i (dec.init_wr),
    .key_ok_i  (wdata_i == INIT_KEY),
    .active_o  (active)
  );

  gate_window #(.WIN_SLOW(WIN_SLOW)) i_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_wr_i  (dec.acc_wr),
    .key_ok_i  (wdata_i[15:0] == WIN_KEY),
    .slow_en_i (slow_en_i),
    .open_o    (win_raw)
  );

  gate_rate_limiter #(.RATE_WIN(RATE_WIN), .RATE_MAX(RATE_MAX)) i_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .busy_o (busy)
  );

  assign active_o   = active;
  assign busy_o     = busy;
  assign win_open_o = win_raw && !busy;
  assign prot_we_o  = dec.prot_wr && active && win_raw && !busy;

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit_init) begin
      rdata_o[ACT_BIT] = active;
    end else if (rd_i && hit_acc) begin
      rdata_o[WEN_BIT]  = win_raw && !busy;
      rdata_o[BUSY_BIT] = busy;
    end
  end

  a_r9_we_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (active_o && win_open_o && !busy_o && wr_i));
  a_r8_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !win_open_o);
  a_r9_keys_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_init || hit_acc) |-> !prot_we_o);
endmodule

// File: tb/test_rtc_access_gate.sv
module test_rtc_access_gate;
  localparam int AW = 9;
  localparam int WS = 8;
  localparam int RW = 32;
  localparam int RM = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [31:0]   rdata;
  logic          active, win_open, busy, prot_we;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic last_we;

  always #5 clk = ~clk;

  rtc_access_gate #(.ADDR_W(AW), .WIN_SLOW(WS), .RATE_WIN(RW), .RATE_MAX(RM)) i_rtc_access_gate (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .active_o(active), .win_open_o(win_open), .busy_o(busy), .prot_we_o(prot_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    #1 last_we = prot_we;
    @(negedge clk); wr = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 v = rdata; rd = 1'b0;
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_en = 1'b1;
      @(negedge clk); slow_en = 1'b0;
    end
  endtask

  task automatic flush();
    repeat (RW + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 active", active, 0);
    check("R1 win", win_open, 0);
    check("R1 busy", busy, 0);
    check("R1 we", prot_we, 0);
    do_rd(9'h000, v); check("R1 init read", v, 0);
    do_rd(9'h004, v); check("R1 acc read", v, 0);
  endtask

  task automatic t_activation();
    logic [31:0] v;
    do_wr(9'h004, 32'h0000_A965);
    do_wr(9'h010, 32'h1234_5678);
    check("R9 inactive blocks we", last_we, 0);
    do_wr(9'h000, 32'hA5EB_1356);
    check("R2 wrong key", active, 0);
    do_rd(9'h000, v); check("R3 read inactive", v, 0);
    do_wr(9'h000, 32'hA5EB_1357);
    check("R2 right key", active, 1);
    do_rd(9'h000, v); check("R3 read active", v, 32'h1);
    do_wr(9'h000, 32'h0000_0000);
    check("R2 sticky", active, 1);
    do_wr(9'h010, 32'h1);
    check("R9 open active we", last_we, 1);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_wr(9'h004, 32'hFFFF_A965);
    check("R4 open", win_open, 1);
    do_rd(9'h004, v); check("R4 read flag, key zero", v, 32'h0001_0000);
    pulse_slow(WS - 1);
    check("R5 before expiry", win_open, 1);
    pulse_slow(1);
    check("R5 expired", win_open, 0);
    do_wr(9'h010, 32'h2);
    check("R9 closed blocks we", last_we, 0);
    do_wr(9'h004, 32'h0000_A965);
    pulse_slow(5);
    do_wr(9'h004, 32'h0000_A965);
    pulse_slow(WS - 1);
    check("R5 restart holds", win_open, 1);
    pulse_slow(1);
    check("R5 restart expiry", win_open, 0);
    do_wr(9'h004, 32'h0000_A965);
    do_wr(9'h004, 32'h0000_A964);
    check("R6 bad low key", win_open, 0);
    do_wr(9'h004, 32'h0000_A965);
    do_wr(9'h004, 32'hA965_0000);
    check("R6 key in high half", win_open, 0);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    do_wr(9'h004, 32'h0000_A965);
    flush();
    for (int i = 0; i < RM; i++) begin
      @(negedge clk); addr = 9'h010; wdata = i; wr = 1'b1;
    end
    @(negedge clk); wr = 1'b0;
    check("R7 at limit", busy, 0);
    @(negedge clk); wr = 1'b1;
    #1 check("R9 write before busy", prot_we, 1);
    @(negedge clk); wr = 1'b0;
    check("R7 over limit", busy, 1);
    check("R8 masked", win_open, 0);
    do_rd(9'h004, v); check("R8 read while busy", v, 32'h0100_0000);
    do_wr(9'h010, 32'h3);
    check("R9 busy blocks we", last_we, 0);
    flush();
    check("R7 cleared", busy, 0);
    check("R8 unmasked", win_open, 1);
    do_rd(9'h004, v); check("R8 read after busy", v, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_activation();
    t_window();
    t_busy();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule